// File: doc/BRIEF.md
# Dual-Slot SD Host Register Wrapper

This block is the register front end that sits ahead of two SD host slot controllers inside a 4 KiB address window. Each 32-bit bus request is decoded into one of four kinds: a word of the wrapper's own global register file, a shadow copy of a slot's capability word or maximum-current word, a forwarded access into one of the slot sub-windows, or a rejected access (wrong size or out of bounds). The capability and maximum-current shadows drive output buses that the slot controllers read. A slot does not keep its own copy of these words.

The wrapper also samples the two slot interrupt lines. Each line sets or clears one bit in an interrupt status word. A single shared interrupt output follows the most recent edge seen on either line, so it does not follow the OR of the status bits. Requests use a valid/ready handshake. Each accepted request gets a registered response one cycle later.

Top module: `sdw_top`

## Requirements
- R1: After reset, word 0x00 reads 0x00030000 and word 0x04 reads 0x00000005. Every other plain global word and the status word at 0xFC read zero. Each capability shadow holds the parameter CAP_RST and each maximum-current shadow holds zero. irq_out is low.
- R2: Every accepted request (req_valid high; req_ready is always high) produces rsp_valid exactly one cycle later. A read of a plain global word (page 0, req_addr[11:8]=0) returns the last 32-bit value written there. Writes return rsp_rdata zero. Valid in-range accesses return rsp_err low.
- R3: For slot i, offset 0x10+0x10*i aliases the capability word and 0x18+0x10*i aliases the maximum-current word. A write there updates slot_cap or slot_maxc lane i (bits 32*i+31..32*i). A read there returns that value. Neither shadow changes without a write.
- R4: A request whose req_size is not 2 (the encoding 2 means 4 bytes; 0, 1 and 3 mean 1, 2 and 8 bytes) is rejected: no state changes, no slot is selected, rsp_rdata is zero and rsp_err is high.
- R5: A 32-bit request at a page beyond the last slot window (0x300 to 0xFFF with two slots) reads zero and discards its write, with rsp_err high.
- R6: Page 1 forwards to slot 0 and page 2 forwards to slot 1. During the request cycle slot_sel is one-hot on that slot, slot_addr carries req_addr[7:0], and slot_we and slot_wdata copy the request. A read returns that slot's slot_rdata lane.
- R7: Interrupt status bit n (word 0xFC) is set two clock edges after slot_irq[n] goes high and is cleared two edges after it goes low.
- R8: irq_out goes high two edges after any slot_irq line rises. It goes low two edges after any line falls, even while another status bit stays set. If a rise and a fall land on the same edge, the rise wins.
- R9: A slot_irq level that is held steady causes no further change on irq_out.
- R10: If a write to 0xFC takes effect on the same edge as an interrupt edge, the edge-affected status bits take their edge value and all other bits take the written data.
- R11: slot_spec_ver carries the value 2 in each slot's 8-bit lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; every request is taken |
| req_addr | input | 12 | Byte address in the 4 KiB window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | log2 of access bytes; only 2 is valid |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Rejected access (size or range) |
| slot_sel | output | NS | One-hot slot window select |
| slot_addr | output | 8 | Offset inside the slot window |
| slot_we | output | 1 | Forwarded write enable |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32*NS | Combinational read data from each slot |
| slot_irq | input | NS | Slot interrupt levels |
| irq_out | output | 1 | Shared interrupt |
| slot_cap | output | 32*NS | Capability shadow per slot |
| slot_maxc | output | 32*NS | Maximum-current shadow per slot |
| slot_spec_ver | output | 8*NS | Host specification version per slot |

## Verification
The bus path and the interrupt path both write the status word at 0xFC. A software write to that word can therefore take effect on the same edge as an edge-driven status update. The bench provokes this case by changing slot_irq at one falling clock edge and issuing the 0xFC write at the next falling edge, so that both take effect on the same rising edge. It then reads the word back. The expected value is the written data with each edge-affected bit replaced by its new level. The bench repeats this for a rise and for a fall, and checks irq_out each time.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   localparam int GLOBAL_BYTES = 256;
   localparam int GWORDS       = GLOBAL_BYTES / 4;
   localparam int GIDX_W       = $clog2(GWORDS);
   localparam logic [1:0] SIZE_WORD = 2'd2;

   typedef enum logic [2:0] {
      TGT_GLOBAL, TGT_CAP, TGT_MAXC, TGT_SLOT, TGT_OOB, TGT_BADSZ
   } tgt_e;

   typedef struct packed {
      tgt_e              tgt;
      logic [1:0]        slot;
      logic [GIDX_W-1:0] widx;
      logic [7:0]        sub;
   } dec_t;
endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
   import sdw_pkg::*;
#(
   parameter int NS = 2
) (
   input  logic [11:0] addr,
   input  logic [1:0]  size,
   output dec_t        dec
);
   logic [3:0] page;
   assign page = addr[11:8];

   always_comb begin
      dec      = '0;
      dec.tgt  = TGT_GLOBAL;
      dec.widx = addr[7:2];
      dec.sub  = addr[7:0];
      if (size != SIZE_WORD) begin
         dec.tgt = TGT_BADSZ;
      end else if (page == 4'd0) begin
         for (int i = 0; i < NS; i++) begin
            if (addr[7:0] == 8'(16 * (i + 1))) begin
               dec.tgt  = TGT_CAP;
               dec.slot = 2'(i);
            end
            if (addr[7:0] == 8'(16 * (i + 1) + 8)) begin
               dec.tgt  = TGT_MAXC;
               dec.slot = 2'(i);
            end
         end
      end else if (page <= 4'(NS)) begin
         dec.tgt  = TGT_SLOT;
         dec.slot = 2'(page - 4'd1);
      end else begin
         dec.tgt = TGT_OOB;
      end
   end
endmodule

// File: rtl/sdw_irq.sv
module sdw_irq #(
   parameter int NS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] irq_in,
   output logic [NS-1:0] rise,
   output logic [NS-1:0] fall,
   output logic          irq_out
);
   logic [NS-1:0] smp_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q  <= '0;
         prev_q <= '0;
      end else begin
         smp_q  <= irq_in;
         prev_q <= smp_q;
      end
   end

   assign rise = smp_q & ~prev_q;
   assign fall = ~smp_q & prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_out <= 1'b0;
      else if (|rise)  irq_out <= 1'b1;
      else if (|fall)  irq_out <= 1'b0;
   end
endmodule

// File: rtl/sdw_regs.sv
module sdw_regs
   import sdw_pkg::*;
#(
   parameter int          NS       = 2,
   parameter logic [31:0] INFO_RST = 32'h0003_0000,
   parameter logic [31:0] DEB_RST  = 32'h0000_0005,
   parameter logic [31:0] CAP_RST  = 32'h01E8_0080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  tgt_e              tgt,
   input  logic [1:0]        slot,
   input  logic [GIDX_W-1:0] widx,
   input  logic [31:0]       wdata,
   input  logic [NS-1:0]     irq_set,
   input  logic [NS-1:0]     irq_clr,
   output logic [31:0]       rdata,
   output logic [32*NS-1:0]  cap_o,
   output logic [32*NS-1:0]  maxc_o
);
   localparam int STAT_IDX = GWORDS - 1;

   logic [31:0] mem [GWORDS];
   logic [31:0] cap_q  [NS];
   logic [31:0] maxc_q [NS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < GWORDS; k++)
            mem[k] <= (k == 0) ? INFO_RST : (k == 1) ? DEB_RST : 32'h0;
      end else begin
         if (wr && tgt == TGT_GLOBAL) mem[widx] <= wdata;
         for (int n = 0; n < NS; n++) begin
            if (irq_set[n])      mem[STAT_IDX][n] <= 1'b1;
            else if (irq_clr[n]) mem[STAT_IDX][n] <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < NS; i++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cap_q[i]  <= CAP_RST;
            maxc_q[i] <= 32'h0;
         end else if (wr && slot == 2'(i)) begin
            if (tgt == TGT_CAP)  cap_q[i]  <= wdata;
            if (tgt == TGT_MAXC) maxc_q[i] <= wdata;
         end
      end
      assign cap_o[32*i +: 32]  = cap_q[i];
      assign maxc_o[32*i +: 32] = maxc_q[i];
   end

   always_comb begin
      rdata = 32'h0;
      if (tgt == TGT_GLOBAL) rdata = mem[widx];
      for (int i = 0; i < NS; i++) begin
         if (slot == 2'(i) && tgt == TGT_CAP)  rdata = cap_q[i];
         if (slot == 2'(i) && tgt == TGT_MAXC) rdata = maxc_q[i];
      end
   end
endmodule

// File: rtl/sdw_top.sv
module sdw_top
   import sdw_pkg::*;
#(
   parameter int          NS       = 2,
   parameter logic [31:0] INFO_RST = 32'h0003_0000,
   parameter logic [31:0] DEB_RST  = 32'h0000_0005,
   parameter logic [31:0] CAP_RST  = 32'h01E8_0080,
   parameter logic [7:0]  SPEC_VER = 8'd2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [11:0]      req_addr,
   input  logic             req_we,
   input  logic [1:0]       req_size,
   input  logic [31:0]      req_wdata,
   output logic             rsp_valid,
   output logic [31:0]      rsp_rdata,
   output logic             rsp_err,
   output logic [NS-1:0]    slot_sel,
   output logic [7:0]       slot_addr,
   output logic             slot_we,
   output logic [31:0]      slot_wdata,
   input  logic [32*NS-1:0] slot_rdata,
   input  logic [NS-1:0]    slot_irq,
   output logic             irq_out,
   output logic [32*NS-1:0] slot_cap,
   output logic [32*NS-1:0] slot_maxc,
   output logic [8*NS-1:0]  slot_spec_ver
);
   if (NS < 1 || NS > 4) begin : g_bad_ns
      $error("sdw_top: NS must lie in 1..4");
   end
   if (GLOBAL_BYTES * (NS + 1) > 4096) begin : g_bad_map
      $error("sdw_top: slot windows exceed the 4 KiB window");
   end

   dec_t          dec;
   logic          fire;
   logic [31:0]   reg_rdata;
   logic [31:0]   slot_mux;
   logic [NS-1:0] rise, fall;

   assign req_ready = 1'b1;
   assign fire      = req_valid;

   sdw_decode #(.NS(NS)) u_dec (
      .addr(req_addr), .size(req_size), .dec(dec)
   );

   sdw_irq #(.NS(NS)) u_irq (
      .clk(clk), .rst_n(rst_n), .irq_in(slot_irq),
      .rise(rise), .fall(fall), .irq_out(irq_out)
   );

   sdw_regs #(
      .NS(NS), .INFO_RST(INFO_RST), .DEB_RST(DEB_RST), .CAP_RST(CAP_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(fire && req_we),
      .tgt(dec.tgt), .slot(dec.slot), .widx(dec.widx), .wdata(req_wdata),
      .irq_set(rise), .irq_clr(fall), .rdata(reg_rdata),
      .cap_o(slot_cap), .maxc_o(slot_maxc)
   );

   for (genvar i = 0; i < NS; i++) begin : g_port
      assign slot_sel[i] = fire && dec.tgt == TGT_SLOT && dec.slot == 2'(i);
      assign slot_spec_ver[8*i +: 8] = SPEC_VER;
   end
   assign slot_addr  = dec.sub;
   assign slot_we    = req_we;
   assign slot_wdata = req_wdata;

   always_comb begin
      slot_mux = 32'h0;
      for (int i = 0; i < NS; i++)
         if (slot_sel[i]) slot_mux = slot_rdata[32*i +: 32];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= 32'h0;
      end else begin
         rsp_valid <= fire;
         rsp_err   <= fire && (dec.tgt == TGT_OOB || dec.tgt == TGT_BADSZ);
         if (!fire || req_we)          rsp_rdata <= 32'h0;
         else if (dec.tgt == TGT_SLOT) rsp_rdata <= slot_mux;
         else                          rsp_rdata <= reg_rdata;
      end
   end
endmodule

// File: rtl/sdw_chk.sv
module sdw_chk #(
   parameter int NS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_we,
   input logic [11:0]      req_addr,
   input logic [1:0]       req_size,
   input logic             rsp_valid,
   input logic             rsp_err,
   input logic [NS-1:0]    slot_sel,
   input logic [NS-1:0]    slot_irq,
   input logic             irq_out,
   input logic [32*NS-1:0] slot_cap,
   input logic [32*NS-1:0] slot_maxc
);
   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_err_in_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);
   assert_badsize_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 2'd2) |=> rsp_err);
   assert_badsize_nosel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 2'd2) |-> slot_sel == '0);
   assert_oob_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd2 && req_addr[11:8] > 4'(NS)) |=> rsp_err);
   assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_sel));
   assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_we) |=> ($stable(slot_cap) && $stable(slot_maxc)));
   assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(slot_irq & ~$past(slot_irq))) |=> ##1 irq_out);
   assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(~slot_irq & $past(slot_irq))) && !(|(slot_irq & ~$past(slot_irq))))
      |=> ##1 !irq_out);
endmodule

bind sdw_top sdw_chk #(.NS(NS)) u_chk (.*);

// File: tb/sim_sdw_top.sv
module sim_sdw_top;
   localparam int NS = 2;
   localparam logic [31:0] CAP_RST = 32'h01E8_0080;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready, req_we = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_wdata = '0;
   logic rsp_valid, rsp_err, slot_we, irq_out;
   logic [31:0] rsp_rdata, slot_wdata;
   logic [NS-1:0] slot_sel;
   logic [NS-1:0] slot_irq = '0;
   logic [7:0] slot_addr;
   logic [32*NS-1:0] slot_rdata, slot_cap, slot_maxc;
   logic [8*NS-1:0] slot_spec_ver;

   always #10 clk = ~clk;

   sdw_top #(.NS(NS), .CAP_RST(CAP_RST)) u0 (.*);

   always_comb
      for (int i = 0; i < NS; i++)
         slot_rdata[32*i +: 32] = 32'h5A00_0000 | (32'(i) << 12) | {24'h0, slot_addr};

   int nchk = 0, nerr = 0;
   bit done = 0;
   logic [31:0] gm [64];
   logic [31:0] mcap [NS], mmax [NS];
   logic [NS-1:0] mirq = '0;
   logic mout = 1'b0;

   task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic int page_of(input logic [11:0] a); return int'(a[11:8]); endfunction

   function automatic logic [31:0] model_read(input logic [11:0] a, input logic [1:0] sz);
      int p = page_of(a);
      if (sz != 2'd2) return 32'h0;
      if (p == 0) begin
         for (int i = 0; i < NS; i++) begin
            if (a[7:0] == 8'(16*(i+1)))   return mcap[i];
            if (a[7:0] == 8'(16*(i+1)+8)) return mmax[i];
         end
         return gm[a[7:2]];
      end
      if (p <= NS) return 32'h5A00_0000 | (32'(p-1) << 12) | {24'h0, a[7:0]};
      return 32'h0;
   endfunction

   function automatic void model_write(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
      bit hit = 0;
      if (sz != 2'd2 || page_of(a) != 0) return;
      for (int i = 0; i < NS; i++) begin
         if (a[7:0] == 8'(16*(i+1)))   begin mcap[i] = d; hit = 1; end
         if (a[7:0] == 8'(16*(i+1)+8)) begin mmax[i] = d; hit = 1; end
      end
      if (!hit) gm[a[7:2]] = d;
   endfunction

   function automatic void model_irq(input logic [NS-1:0] v);
      logic [NS-1:0] r = v & ~mirq, f = ~v & mirq;
      gm[63][NS-1:0] = (gm[63][NS-1:0] | r) & ~f;
      if (|r) mout = 1'b1;
      else if (|f) mout = 1'b0;
      mirq = v;
   endfunction

   task automatic access(input logic [11:0] a, input logic we, input logic [1:0] sz,
                         input logic [31:0] d, input string rq);
      logic [31:0] exp;
      bit bad;
      @(negedge clk);
      req_valid = 1; req_addr = a; req_we = we; req_size = sz; req_wdata = d;
      #1;
      bad = (sz != 2'd2) || page_of(a) > NS;
      if (sz == 2'd2 && page_of(a) >= 1 && page_of(a) <= NS) begin
         check(slot_sel == NS'(1 << (page_of(a)-1)) && slot_addr == a[7:0] &&
               slot_we == we && slot_wdata == d, "R6 forward", {slot_sel, slot_addr}, {NS'(1 << (page_of(a)-1)), a[7:0]});
      end else begin
         check(slot_sel == '0, bad ? "R4/R5 no select" : "R6 no select", 32'(slot_sel), 0);
      end
      exp = we ? 32'h0 : model_read(a, sz);
      if (we) model_write(a, sz, d);
      @(negedge clk);
      req_valid = 0;
      check(rsp_valid === 1'b1, "R2 rsp_valid", 32'(rsp_valid), 1);
      check(rsp_rdata === exp, rq, rsp_rdata, exp);
      check(rsp_err === bad, bad ? "R4/R5 err" : "R2 no err", 32'(rsp_err), 32'(bad));
   endtask

   task automatic set_irq(input logic [NS-1:0] v);
      @(negedge clk);
      slot_irq = v;
      repeat (2) @(posedge clk);
      model_irq(v);
      @(negedge clk);
      check(irq_out === mout, "R8/R9 irq_out", 32'(irq_out), 32'(mout));
      check(rsp_valid === 1'b0, "R2 idle", 32'(rsp_valid), 0);
   endtask

   task automatic collide(input logic [NS-1:0] v, input logic [31:0] d);
      @(negedge clk);
      slot_irq = v;
      @(negedge clk);
      req_valid = 1; req_addr = 12'h0FC; req_we = 1; req_size = 2; req_wdata = d;
      gm[63] = d;
      @(posedge clk);
      model_irq(v);
      @(negedge clk);
      req_valid = 0;
      check(irq_out === mout, "R8 irq_out in collision", 32'(irq_out), 32'(mout));
      access(12'h0FC, 0, 2, 0, "R10 status after write/edge collision");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd20811);
      for (int k = 0; k < 64; k++) gm[k] = (k == 0) ? 32'h0003_0000 : (k == 1) ? 32'h5 : 32'h0;
      for (int i = 0; i < NS; i++) begin mcap[i] = CAP_RST; mmax[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      check(irq_out === 1'b0, "R1 irq_out", 32'(irq_out), 0);
      for (int i = 0; i < NS; i++) begin
         check(slot_cap[32*i +: 32] === CAP_RST, "R1 cap shadow", slot_cap[32*i +: 32], CAP_RST);
         check(slot_maxc[32*i +: 32] === 0, "R1 maxc shadow", slot_maxc[32*i +: 32], 0);
         check(slot_spec_ver[8*i +: 8] === 8'd2, "R11 spec version", 32'(slot_spec_ver[8*i +: 8]), 2);
      end
      access(12'h000, 0, 2, 0, "R1 info reset");
      access(12'h004, 0, 2, 0, "R1 debounce reset");
      access(12'h008, 0, 2, 0, "R1 zero word");
      access(12'h0FC, 0, 2, 0, "R1 status reset");

      // R2 plain storage
      access(12'h040, 1, 2, 32'hDEAD_BEEF, "R2 write");
      access(12'h040, 0, 2, 0, "R2 readback");
      // R3 shadows
      access(12'h010, 1, 2, 32'h1111_0000, "R3 write cap0");
      access(12'h028, 1, 2, 32'h0000_2222, "R3 write maxc1");
      check(slot_cap[31:0] === 32'h1111_0000, "R3 cap0 out", slot_cap[31:0], 32'h1111_0000);
      check(slot_maxc[63:32] === 32'h0000_2222, "R3 maxc1 out", slot_maxc[63:32], 32'h2222);
      access(12'h010, 0, 2, 0, "R3 read cap0");
      access(12'h028, 0, 2, 0, "R3 read maxc1");
      // R4 bad size
      access(12'h044, 1, 2'd1, 32'hFFFF_FFFF, "R4 halfword write");
      access(12'h044, 0, 2'd3, 0, "R4 wide read");
      access(12'h044, 0, 2, 0, "R4 word untouched");
      access(12'h110, 0, 2'd0, 0, "R4 byte into slot");
      // R5 out of bounds
      access(12'h300, 1, 2, 32'h1234_5678, "R5 oob write");
      access(12'hFFC, 0, 2, 0, "R5 oob read");
      // R6 slot windows
      access(12'h134, 0, 2, 0, "R6 slot0 read");
      access(12'h2F8, 1, 2, 32'hCAFE_0001, "R6 slot1 write");
      access(12'h208, 0, 2, 0, "R6 slot1 read");

      // R7/R8/R9 interrupts
      set_irq(2'b01);  access(12'h0FC, 0, 2, 0, "R7 bit0 set");
      set_irq(2'b11);  access(12'h0FC, 0, 2, 0, "R7 bit1 set");
      set_irq(2'b01);  access(12'h0FC, 0, 2, 0, "R8 fall clears out, bit0 held");
      repeat (5) @(negedge clk);
      check(irq_out === 1'b0, "R9 steady level no retrigger", 32'(irq_out), 0);
      set_irq(2'b10);  access(12'h0FC, 0, 2, 0, "R8 rise wins over fall");
      set_irq(2'b00);  access(12'h0FC, 0, 2, 0, "R7 all clear");

      // R10 write colliding with edges
      collide(2'b01, 32'hA5A5_A5A4);
      collide(2'b00, 32'h0F0F_0F0F);

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom % 6);
         logic [31:0] d = $urandom;
         case (op)
            0: access({4'h0, 6'($urandom % 64), 2'b00}, 1, 2, d, "R2/R3 rand write");
            1: access({4'h0, 6'($urandom % 64), 2'b00}, 0, 2, 0, "R2/R3 rand read");
            2: access({4'(1 + $urandom % NS), 6'($urandom), 2'b00}, 1'($urandom), 2, d, "R6 rand slot");
            3: access({4'(NS + 1 + $urandom % (15 - NS)), 8'($urandom)}, 1'($urandom), 2, d, "R5 rand oob");
            4: begin
                  logic [1:0] sz = 2'($urandom % 3); sz = (sz == 2) ? 2'd3 : sz;
                  access({4'($urandom % 3), 6'($urandom), 2'b00}, 1'($urandom), sz, d, "R4 rand size");
               end
            default: set_irq(NS'($urandom));
         endcase
      end
      for (int i = 0; i < NS; i++) begin
         check(slot_cap[32*i +: 32] === mcap[i], "R3 final cap", slot_cap[32*i +: 32], mcap[i]);
         check(slot_maxc[32*i +: 32] === mmax[i], "R3 final maxc", slot_maxc[32*i +: 32], mmax[i]);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule